// File: doc/BRIEF.md
# Weighted-Replacement Trace Cache Array

This block is a small, fully associative store of fetch traces. Each line holds one trace of up to `MAX_BLK` basic blocks and `MAX_INSN` instructions. It is tagged by the start address of the trace and by the predicted outcomes of the conditional branches that end its inner blocks. The front end presents a start PC and the current predicted outcomes on the lookup port. After a fixed latency, the block answers with hit or miss, the packed instruction words, the instruction count and the address to fetch after the trace. Completed traces from the line-fill buffer arrive on the fill port.

When a fill finds no free line, the line to evict is not chosen by recency. Every line carries separate weight fields: a 2-bit hit counter, its basic-block count, its count of taken transitions, and a term mapped from the branch predictor's current counter for that line, which arrives every cycle. The sum of these fields is the line's weight, and the line with the lowest sum is evicted. The hit counter only counts inside a programmable activity window. When that window runs out, all hit counters are cleared.

A control state machine sequences the work through four states. `ST_IDLE` accepts a lookup or a fill. `ST_PROBE` compares all tags and registers the answer. `ST_SCAN` steps through the lines one per cycle to select the victim. `ST_COMMIT` writes the chosen line. The transitions are:
- IDLE→PROBE on an accepted lookup.
- IDLE→SCAN on an accepted fill.
- PROBE→IDLE after one cycle.
- SCAN→COMMIT after the last line has been examined.
- COMMIT→IDLE after one cycle.

Top module: `tc_trace_array`

## Requirements
- R1: After reset every line is invalid, so any lookup misses. In the idle state with no request pending, `lk_ready` and `fl_ready` are high and `lk_done` and `fl_done` are low.
- R2: A lookup hits when a valid line has the same start PC and agrees on every prediction bit b with b+1 < that line's block count. Bit b is the predicted outcome of the branch ending block b, with 1 meaning taken. On a hit the block returns that line's instruction words, count and next-fetch PC. If `lk_valid` is sampled at edge N, then `lk_done` is high for exactly the one cycle after edge N+1.
- R3: Prediction bits at or beyond the line's block count minus one have no effect on a lookup. A differing bit inside that range gives a miss.
- R4: A fill that matches no line is written into the lowest-indexed invalid line if one exists.
- R5: A fill with the same start PC and the same relevant prediction bits as a valid line overwrites that line.
- R6: With every line valid and no tag match, the victim is the line of minimum weight. Ties go to the lowest index. Weight = hit counter + block count + taken-transition count + predictor term.
- R7: The predictor term of line i comes from `bp_ctr[2i+1:2i]`. A counter value of 0 maps to 0, and any other value maps to 2.
- R8: A hit raises that line's 2-bit hit counter, saturating at 3. This happens only while the activity window is running. Hits at any other time leave the counter unchanged.
- R9: Writing `win_len` through `win_wr` starts a window of that many cycles. When the window runs out, every hit counter is cleared.
- R10: After an accepted fill, `fl_done` is high with the written line on `fl_way` for the single cycle after NUM_LINES+1 rising edges. The count starts at the accepting edge, and both ready outputs stay low until then. A lookup takes precedence over a fill: `fl_ready` is low while `lk_valid` is high.
- R11: A freshly written line starts with a hit counter of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Lookup start address |
| lk_pred | input | MAX_BLK-1 | Predicted outcomes, bit b for branch ending block b |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup found a line |
| lk_insns | output | MAX_INSN*INSN_W | Instruction words, word k at bits k*INSN_W |
| lk_ninsn | output | clog2(MAX_INSN+1) | Instruction count |
| lk_next_pc | output | PC_W | Fetch address after the trace |
| fl_valid | input | 1 | Fill request |
| fl_ready | output | 1 | Fill can be accepted |
| fl_pc | input | PC_W | Trace start address |
| fl_pred | input | MAX_BLK-1 | Inner branch outcomes of the trace |
| fl_nblk | input | clog2(MAX_BLK+1) | Basic-block count |
| fl_ntaken | input | clog2(MAX_BLK) | Taken transitions inside the trace |
| fl_ninsn | input | clog2(MAX_INSN+1) | Instruction count |
| fl_insns | input | MAX_INSN*INSN_W | Instruction words |
| fl_next_pc | input | PC_W | Fetch address after the trace |
| fl_done | output | 1 | Fill written |
| fl_way | output | clog2(NUM_LINES) | Line that was written |
| bp_ctr | input | 2*NUM_LINES | Current predictor counter per line |
| win_wr | input | 1 | Load activity-window length |
| win_len | input | WIN_W | Window length in cycles |

## Verification
Some properties are checked on every cycle:
- `lk_done` and `fl_done` are single-cycle pulses.
- A hit never reports an empty or oversized count.
- After a commit the block is idle again.
- The window closes on the cycle after expiry.
- The total of the hit counters never grows while the window is idle.

Other behaviour can only be shown by the directed scenarios, which drive sequences and look at the outcome:
- which line a fill evicts, and the tie-break between equal weights;
- the predictor mapping;
- saturation of the hit counter, clearing on expiry, and the window restart;
- the reset of the hit counter when a line is rewritten;
- prediction-bit masking and the latencies.

// File: rtl/tc_pkg.sv
package tc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PROBE,
        ST_SCAN,
        ST_COMMIT
    } tc_state_e;

    // Predictor counter to weight term: an untrained (zero) counter scores low.
    function automatic logic [1:0] ctr_term(input logic [1:0] ctr);
        return (ctr == 2'd0) ? 2'd0 : 2'd2;
    endfunction

endpackage

// File: rtl/tc_line_weight.sv
module tc_line_weight #(
    parameter int BLK_W = 2,
    parameter int TK_W  = 2,
    parameter int WGT_W = 4
) (
    input  logic [1:0]       hits,
    input  logic [BLK_W-1:0] nblk,
    input  logic [TK_W-1:0]  ntaken,
    input  logic [1:0]       ctr,
    output logic [WGT_W-1:0] wgt
);
    import tc_pkg::*;

    always_comb begin
        wgt = WGT_W'(hits) + WGT_W'(nblk) + WGT_W'(ntaken) + WGT_W'(ctr_term(ctr));
    end

endmodule

// File: rtl/tc_window.sv
module tc_window #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIN_W-1:0] len,
    output logic             active,
    output logic             expire
);
    logic [WIN_W-1:0] left_q;

    assign active = (left_q != '0);
    assign expire = active && (left_q == WIN_W'(1)) && !wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (wr) begin
            left_q <= len;
        end else if (active) begin
            left_q <= left_q - WIN_W'(1);
        end
    end

endmodule

// File: rtl/tc_victim_scan.sv
module tc_victim_scan #(
    parameter int NUM_LINES = 32,
    parameter int IDX_W     = 5,
    parameter int WGT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    input  logic             cur_valid,
    input  logic             cur_match,
    input  logic [WGT_W-1:0] cur_wgt,
    output logic [IDX_W-1:0] idx,
    output logic             last,
    output logic [IDX_W-1:0] pick
);
    logic             got_match_q;
    logic             got_free_q;
    logic             got_any_q;
    logic [WGT_W-1:0] best_w_q;

    assign last = (idx == IDX_W'(NUM_LINES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx         <= '0;
            pick        <= '0;
            got_match_q <= 1'b0;
            got_free_q  <= 1'b0;
            got_any_q   <= 1'b0;
            best_w_q    <= '0;
        end else if (start) begin
            idx         <= '0;
            pick        <= '0;
            got_match_q <= 1'b0;
            got_free_q  <= 1'b0;
            got_any_q   <= 1'b0;
            best_w_q    <= '0;
        end else if (step) begin
            if (!last) begin
                idx <= idx + IDX_W'(1);
            end
            // Priority: tag match, then first free line, then first minimum weight.
            if (!got_match_q) begin
                if (cur_match) begin
                    got_match_q <= 1'b1;
                    pick        <= idx;
                end else if (!got_free_q) begin
                    if (!cur_valid) begin
                        got_free_q <= 1'b1;
                        pick       <= idx;
                    end else if (!got_any_q || (cur_wgt < best_w_q)) begin
                        got_any_q <= 1'b1;
                        best_w_q  <= cur_wgt;
                        pick      <= idx;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/tc_trace_array.sv
module tc_trace_array #(
    parameter int NUM_LINES = 32,
    parameter int PC_W      = 32,
    parameter int INSN_W    = 32,
    parameter int MAX_INSN  = 16,
    parameter int MAX_BLK   = 3,
    parameter int WIN_W     = 16,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int PRED_W   = MAX_BLK - 1,
    localparam int BLK_W    = $clog2(MAX_BLK + 1),
    localparam int TK_W     = (MAX_BLK > 1) ? $clog2(MAX_BLK) : 1,
    localparam int CNT_W    = $clog2(MAX_INSN + 1),
    localparam int DATA_W   = MAX_INSN * INSN_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_valid,
    input  logic [PC_W-1:0]        lk_pc,
    input  logic [PRED_W-1:0]      lk_pred,
    output logic                   lk_ready,
    output logic                   lk_done,
    output logic                   lk_hit,
    output logic [DATA_W-1:0]      lk_insns,
    output logic [CNT_W-1:0]       lk_ninsn,
    output logic [PC_W-1:0]        lk_next_pc,
    input  logic                   fl_valid,
    output logic                   fl_ready,
    input  logic [PC_W-1:0]        fl_pc,
    input  logic [PRED_W-1:0]      fl_pred,
    input  logic [BLK_W-1:0]       fl_nblk,
    input  logic [TK_W-1:0]        fl_ntaken,
    input  logic [CNT_W-1:0]       fl_ninsn,
    input  logic [DATA_W-1:0]      fl_insns,
    input  logic [PC_W-1:0]        fl_next_pc,
    output logic                   fl_done,
    output logic [IDX_W-1:0]       fl_way,
    input  logic [2*NUM_LINES-1:0] bp_ctr,
    input  logic                   win_wr,
    input  logic [WIN_W-1:0]       win_len
);
    import tc_pkg::*;

    localparam int WGT_W = $clog2(2 * MAX_BLK + 5);

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [PRED_W-1:0] pred;
        logic [BLK_W-1:0]  nblk;
        logic [TK_W-1:0]   ntaken;
        logic [CNT_W-1:0]  ninsn;
        logic [DATA_W-1:0] data;
        logic [PC_W-1:0]   nxt;
    } line_t;

    tc_state_e state_q, state_d;

    logic [PC_W-1:0]   lq_pc;
    logic [PRED_W-1:0] lq_pred;
    line_t             fq;

    logic [NUM_LINES-1:0] probe_hit;
    logic [NUM_LINES-1:0] fill_hit;
    logic [NUM_LINES-1:0] vld_vec;
    logic [2*NUM_LINES-1:0] hit_flat;
    line_t                line_arr [NUM_LINES];
    logic [WGT_W-1:0]     wgt_arr  [NUM_LINES];

    logic             probe_any;
    logic [IDX_W-1:0] probe_sel;
    logic             win_active;
    logic             win_expire;
    logic             lk_accept;
    logic             fl_accept;
    logic [IDX_W-1:0] scan_idx;
    logic             scan_last;
    logic [IDX_W-1:0] vic_idx;

    assign lk_ready  = (state_q == ST_IDLE);
    assign fl_ready  = (state_q == ST_IDLE) && !lk_valid;
    assign lk_accept = lk_ready && lk_valid;
    assign fl_accept = fl_ready && fl_valid;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (lk_valid) begin
                    state_d = ST_PROBE;
                end else if (fl_valid) begin
                    state_d = ST_SCAN;
                end
            end
            ST_PROBE:  state_d = ST_IDLE;
            ST_SCAN:   if (scan_last) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- request capture ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lq_pc   <= '0;
            lq_pred <= '0;
            fq      <= '0;
        end else begin
            if (lk_accept) begin
                lq_pc   <= lk_pc;
                lq_pred <= lk_pred;
            end
            if (fl_accept) begin
                fq.pc     <= fl_pc;
                fq.pred   <= fl_pred;
                fq.nblk   <= fl_nblk;
                fq.ntaken <= fl_ntaken;
                fq.ninsn  <= fl_ninsn;
                fq.data   <= fl_insns;
                fq.nxt    <= fl_next_pc;
            end
        end
    end

    // ---------------- activity window ----------------
    tc_window #(.WIN_W(WIN_W)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (win_wr),
        .len    (win_len),
        .active (win_active),
        .expire (win_expire)
    );

    // ---------------- per-line storage ----------------
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        line_t      line_q;
        logic       vld_q;
        logic [1:0] hits_q;
        logic       p_ok;
        logic       f_ok;
        logic       wr_here;

        assign wr_here = (state_q == ST_COMMIT) && (vic_idx == IDX_W'(i));

        always_comb begin
            p_ok = 1'b1;
            f_ok = 1'b1;
            for (int b = 0; b < PRED_W; b++) begin
                if ((b + 1) < int'(line_q.nblk)) begin
                    if (lq_pred[b] != line_q.pred[b]) p_ok = 1'b0;
                    if (fq.pred[b] != line_q.pred[b]) f_ok = 1'b0;
                end
            end
        end

        assign probe_hit[i] = vld_q && (line_q.pc == lq_pc) && p_ok;
        assign fill_hit[i]  = vld_q && (line_q.pc == fq.pc) && f_ok;
        assign vld_vec[i]   = vld_q;
        assign line_arr[i]  = line_q;
        assign hit_flat[2*i +: 2] = hits_q;

        tc_line_weight #(.BLK_W(BLK_W), .TK_W(TK_W), .WGT_W(WGT_W)) u_wgt (
            .hits   (hits_q),
            .nblk   (line_q.nblk),
            .ntaken (line_q.ntaken),
            .ctr    (bp_ctr[2*i +: 2]),
            .wgt    (wgt_arr[i])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q  <= 1'b0;
                line_q <= '0;
            end else if (wr_here) begin
                vld_q  <= 1'b1;
                line_q <= fq;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hits_q <= 2'd0;
            end else if (wr_here || win_expire) begin
                hits_q <= 2'd0;
            end else if ((state_q == ST_PROBE) && probe_any && (probe_sel == IDX_W'(i))
                         && win_active && (hits_q != 2'd3)) begin
                hits_q <= hits_q + 2'd1;
            end
        end
    end

    // lowest-index matching line
    always_comb begin
        probe_any = 1'b0;
        probe_sel = '0;
        for (int k = NUM_LINES - 1; k >= 0; k--) begin
            if (probe_hit[k]) begin
                probe_any = 1'b1;
                probe_sel = IDX_W'(k);
            end
        end
    end

    // ---------------- victim selection ----------------
    tc_victim_scan #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .WGT_W(WGT_W)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (fl_accept),
        .step      (state_q == ST_SCAN),
        .cur_valid (vld_vec[scan_idx]),
        .cur_match (fill_hit[scan_idx]),
        .cur_wgt   (wgt_arr[scan_idx]),
        .idx       (scan_idx),
        .last      (scan_last),
        .pick      (vic_idx)
    );

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_done    <= 1'b0;
            lk_hit     <= 1'b0;
            lk_insns   <= '0;
            lk_ninsn   <= '0;
            lk_next_pc <= '0;
            fl_done    <= 1'b0;
            fl_way     <= '0;
        end else begin
            lk_done <= (state_q == ST_PROBE);
            fl_done <= (state_q == ST_COMMIT);
            if (state_q == ST_PROBE) begin
                lk_hit     <= probe_any;
                lk_insns   <= probe_any ? line_arr[probe_sel].data  : '0;
                lk_ninsn   <= probe_any ? line_arr[probe_sel].ninsn : '0;
                lk_next_pc <= probe_any ? line_arr[probe_sel].nxt   : '0;
            end
            if (state_q == ST_COMMIT) begin
                fl_way <= vic_idx;
            end
        end
    end

endmodule

// File: rtl/tc_trace_array_chk.sv
module tc_trace_array_chk #(
    parameter int NUM_LINES = 32,
    parameter int MAX_INSN  = 16,
    parameter int CNT_W     = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lk_done,
    input logic                   lk_hit,
    input logic [CNT_W-1:0]       lk_ninsn,
    input logic                   lk_ready,
    input logic                   fl_done,
    input logic                   win_active,
    input logic                   win_expire,
    input logic [2*NUM_LINES-1:0] hit_flat
);
    logic [$clog2(4*NUM_LINES+1)-1:0] hit_total;

    always_comb begin
        hit_total = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            hit_total = hit_total + $bits(hit_total)'(hit_flat[2*i +: 2]);
        end
    end

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |=> !lk_done);

    assert_hit_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && lk_hit) |-> ((lk_ninsn != '0) && (lk_ninsn <= CNT_W'(MAX_INSN))));

    assert_fill_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fl_done |=> !fl_done);

    assert_commit_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fl_done |-> (lk_ready && !lk_done));

    assert_expire_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
        win_expire |=> !win_active);

    assert_no_count_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !win_active |=> (hit_total <= $past(hit_total)));

endmodule

bind tc_trace_array tc_trace_array_chk #(
    .NUM_LINES (NUM_LINES),
    .MAX_INSN  (MAX_INSN),
    .CNT_W     (CNT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_done    (lk_done),
    .lk_hit     (lk_hit),
    .lk_ninsn   (lk_ninsn),
    .lk_ready   (lk_ready),
    .fl_done    (fl_done),
    .win_active (win_active),
    .win_expire (win_expire),
    .hit_flat   (hit_flat)
);

// File: tb/tc_trace_array_tb_top.sv
module tc_trace_array_tb_top;

    localparam int NUM_LINES = 32;
    localparam int PC_W      = 32;
    localparam int INSN_W    = 32;
    localparam int MAX_INSN  = 16;
    localparam int MAX_BLK   = 3;
    localparam int WIN_W     = 16;
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int PRED_W    = MAX_BLK - 1;
    localparam int BLK_W     = $clog2(MAX_BLK + 1);
    localparam int TK_W      = $clog2(MAX_BLK);
    localparam int CNT_W     = $clog2(MAX_INSN + 1);
    localparam int DATA_W    = MAX_INSN * INSN_W;
    localparam int WIN_LEN   = 2000;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   lk_valid = 1'b0;
    logic [PC_W-1:0]        lk_pc = '0;
    logic [PRED_W-1:0]      lk_pred = '0;
    logic                   lk_ready, lk_done, lk_hit;
    logic [DATA_W-1:0]      lk_insns;
    logic [CNT_W-1:0]       lk_ninsn;
    logic [PC_W-1:0]        lk_next_pc;
    logic                   fl_valid = 1'b0;
    logic                   fl_ready;
    logic [PC_W-1:0]        fl_pc = '0;
    logic [PRED_W-1:0]      fl_pred = '0;
    logic [BLK_W-1:0]       fl_nblk = '0;
    logic [TK_W-1:0]        fl_ntaken = '0;
    logic [CNT_W-1:0]       fl_ninsn = '0;
    logic [DATA_W-1:0]      fl_insns = '0;
    logic [PC_W-1:0]        fl_next_pc = '0;
    logic                   fl_done;
    logic [IDX_W-1:0]       fl_way;
    logic [2*NUM_LINES-1:0] bp_ctr = {NUM_LINES{2'b01}};
    logic                   win_wr = 1'b0;
    logic [WIN_W-1:0]       win_len = '0;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tc_trace_array #(
        .NUM_LINES(NUM_LINES), .PC_W(PC_W), .INSN_W(INSN_W),
        .MAX_INSN(MAX_INSN), .MAX_BLK(MAX_BLK), .WIN_W(WIN_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_pred(lk_pred), .lk_ready(lk_ready),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_insns(lk_insns), .lk_ninsn(lk_ninsn),
        .lk_next_pc(lk_next_pc),
        .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_pc(fl_pc), .fl_pred(fl_pred),
        .fl_nblk(fl_nblk), .fl_ntaken(fl_ntaken), .fl_ninsn(fl_ninsn), .fl_insns(fl_insns),
        .fl_next_pc(fl_next_pc), .fl_done(fl_done), .fl_way(fl_way),
        .bp_ctr(bp_ctr), .win_wr(win_wr), .win_len(win_len)
    );

    function automatic logic [PC_W-1:0] pc_of(input int id);
        return PC_W'(32'h1000 + id * 256);
    endfunction

    function automatic logic [DATA_W-1:0] data_of(input int id, input int salt);
        logic [DATA_W-1:0] d;
        for (int k = 0; k < MAX_INSN; k++) begin
            d[k*INSN_W +: INSN_W] = INSN_W'(pc_of(id) + k * 4 + salt * 32'h10000);
        end
        return d;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_lookup(input int id, input logic [PRED_W-1:0] pred, output logic hit,
                             output logic [DATA_W-1:0] d, output logic [CNT_W-1:0] n,
                             output logic [PC_W-1:0] nx);
        @(negedge clk);
        while (!lk_ready) @(negedge clk);
        lk_valid = 1'b1; lk_pc = pc_of(id); lk_pred = pred;
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R2 done latency", 64'(lk_done), 64'd0);
        @(negedge clk);
        chk("R2 done latency", 64'(lk_done), 64'd1);
        hit = lk_hit; d = lk_insns; n = lk_ninsn; nx = lk_next_pc;
    endtask

    task automatic probe_hit(input int id, input logic [PRED_W-1:0] pred, input logic exp, input string req);
        logic hit; logic [DATA_W-1:0] d; logic [CNT_W-1:0] n; logic [PC_W-1:0] nx;
        do_lookup(id, pred, hit, d, n, nx);
        chk(req, 64'(hit), 64'(exp));
    endtask

    task automatic do_fill(input int id, input int nblk, input int ntk, input int salt,
                           output int way, output int cyc);
        @(negedge clk);
        while (!fl_ready) @(negedge clk);
        fl_valid = 1'b1; fl_pc = pc_of(id); fl_pred = 2'b01;
        fl_nblk = BLK_W'(nblk); fl_ntaken = TK_W'(ntk);
        fl_ninsn = CNT_W'(8 + id % 8); fl_insns = data_of(id, salt);
        fl_next_pc = pc_of(id) + PC_W'(64);
        @(negedge clk);
        fl_valid = 1'b0;
        cyc = 0;
        while (!fl_done) begin
            @(negedge clk);
            cyc++;
        end
        way = int'(fl_way);
    endtask

    task automatic fill_expect(input int id, input int nblk, input int ntk, input int salt,
                               input int exp_way, input string req);
        int way, cyc;
        do_fill(id, nblk, ntk, salt, way, cyc);
        chk(req, 64'(way), 64'(exp_way));
    endtask

    task automatic open_window();
        @(negedge clk);
        win_wr = 1'b1; win_len = WIN_W'(WIN_LEN);
        @(negedge clk);
        win_wr = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1 lk_ready", 64'(lk_ready), 64'd1);
        chk("R1 fl_ready", 64'(fl_ready), 64'd1);
        chk("R1 lk_done", 64'(lk_done), 64'd0);
        chk("R1 fl_done", 64'(fl_done), 64'd0);
        probe_hit(0, 2'b01, 1'b0, "R1 miss after reset");
    endtask

    task automatic t_basic();
        int way, cyc;
        logic hit; logic [DATA_W-1:0] d; logic [CNT_W-1:0] n; logic [PC_W-1:0] nx;
        // lookup has precedence over fill
        @(negedge clk);
        lk_valid = 1'b1; lk_pc = pc_of(9); fl_valid = 1'b1;
        #0; chk("R10 lookup precedence", 64'(fl_ready), 64'd0);
        @(negedge clk);
        lk_valid = 1'b0; fl_valid = 1'b0;
        repeat (2) @(negedge clk);
        do_fill(0, 2, 1, 0, way, cyc);
        chk("R4 first free line", 64'(way), 64'd0);
        chk("R10 fill latency", 64'(cyc), 64'(NUM_LINES + 1));
        do_lookup(0, 2'b01, hit, d, n, nx);
        chk("R2 hit", 64'(hit), 64'd1);
        chk("R2 data", 64'(d == data_of(0, 0)), 64'd1);
        chk("R2 count", 64'(n), 64'd8);
        chk("R2 next pc", 64'(nx), 64'(pc_of(0) + 64));
        probe_hit(0, 2'b11, 1'b1, "R3 upper bit ignored");
        probe_hit(0, 2'b00, 1'b0, "R3 relevant bit mismatch");
        fill_expect(1, 2, 1, 0, 1, "R4 next free line");
    endtask

    task automatic t_overwrite();
        logic hit; logic [DATA_W-1:0] d; logic [CNT_W-1:0] n; logic [PC_W-1:0] nx;
        fill_expect(0, 2, 1, 5, 0, "R5 same tag reuses line");
        do_lookup(0, 2'b01, hit, d, n, nx);
        chk("R5 new data", 64'(d == data_of(0, 5)), 64'd1);
    endtask

    task automatic t_fill_all();
        for (int i = 2; i < NUM_LINES; i++) begin
            fill_expect(i, 2, 1, 0, i, "R4 free lines in order");
        end
        fill_expect(32, 2, 1, 0, 0, "R6 tie lowest index");
        probe_hit(0, 2'b01, 1'b0, "R6 evicted line gone");
        probe_hit(32, 2'b01, 1'b1, "R6 new line present");
    endtask

    task automatic t_ctr_zero();
        bp_ctr[2*5 +: 2] = 2'b00;
        fill_expect(33, 2, 1, 0, 5, "R7 zero counter lowers weight");
        bp_ctr[2*5 +: 2] = 2'b01;
        bp_ctr[2*6 +: 2] = 2'b11;
        bp_ctr[2*2 +: 2] = 2'b10;
        fill_expect(40, 2, 1, 0, 0, "R7 nonzero values equal");
        bp_ctr = {NUM_LINES{2'b01}};
    endtask

    task automatic t_fields();
        fill_expect(7, 1, 0, 1, 7, "R5 refill changes fields");
        fill_expect(34, 2, 1, 0, 7, "R6 fewer blocks and no taken lowest");
    endtask

    task automatic t_saturate();
        open_window();
        bp_ctr[2*14 +: 2] = 2'b00;
        for (int k = 0; k < 5; k++) probe_hit(14, 2'b01, 1'b1, "R8 hit line 14");
        fill_expect(35, 2, 1, 0, 0, "R8 counter saturates at 3");
    endtask

    task automatic t_expire();
        repeat (WIN_LEN + 100) @(negedge clk);
        fill_expect(36, 2, 1, 0, 14, "R9 expiry clears hits");
        bp_ctr[2*14 +: 2] = 2'b01;
    endtask

    task automatic t_idle_hits();
        bp_ctr[2*20 +: 2] = 2'b00;
        for (int k = 0; k < 3; k++) probe_hit(20, 2'b01, 1'b1, "R8 hit outside window");
        fill_expect(37, 2, 1, 0, 20, "R8 no counting outside window");
        bp_ctr[2*20 +: 2] = 2'b01;
    endtask

    task automatic t_restart();
        open_window();
        bp_ctr[2*21 +: 2] = 2'b00;
        for (int k = 0; k < 2; k++) probe_hit(21, 2'b01, 1'b1, "R9 hit after restart");
        fill_expect(38, 2, 1, 0, 0, "R9 window restarted by write");
        bp_ctr[2*21 +: 2] = 2'b01;
    endtask

    task automatic t_new_line();
        bp_ctr[2*22 +: 2] = 2'b00;
        for (int k = 0; k < 3; k++) probe_hit(22, 2'b01, 1'b1, "R11 hit line 22");
        fill_expect(22, 2, 1, 3, 22, "R11 refill same tag");
        fill_expect(39, 2, 1, 0, 22, "R11 fresh line counter zero");
        bp_ctr = {NUM_LINES{2'b01}};
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_overwrite();
        t_fill_all();
        t_ctr_zero();
        t_fields();
        t_saturate();
        t_expire();
        t_idle_hits();
        t_restart();
        t_new_line();
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule